// File: doc/BRIEF.md
# Halt and Wake-up Controller

This block sequences power-down for a small microcontroller core. A one-cycle halt strobe from the instruction decoder puts it into a halted state. There it drops the core clock enable, keeps the watchdog tick enable high only when the watchdog runs from its own oscillator, marks the power-down flag and clears the timeout flag. It also asks the watchdog to clear itself. It drives no clear to RAM, registers or I/O; it only gives control strobes to the surrounding logic.

While halted, the controller watches three wake sources. A watchdog overflow gives a warm-reset strobe, which makes the core zero its program counter and stack pointer. An enabled pending interrupt, or a falling edge on any synchronised port-A pin, gives a plain resume strobe. The active-low external reset pulls the block back to the run state from any state and clears both flags. While running, a watchdog overflow instead gives a full chip-reset strobe and sets the timeout flag. Reading the two flags therefore tells the software which kind of restart took place.

Top module: `hwc_halt_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `pdf` and `to_flag` are 0, `sys_clk_en` is 1, and `wdt_clr`, `chip_rst`, `warm_rst` and `resume` are 0.
- R2: A `halt_req` pulse while running gives, one cycle later, `pdf`=1, `to_flag`=0, a one-cycle `wdt_clr`, and entry to the halted state.
- R3: While halted, `sys_clk_en` is 0. It returns to 1 in the same cycle as the strobe that ends the halt.
- R4: While halted, `wdt_tick_en` equals `wdt_osc_sel`. While running, it is 1.
- R5: A `wdt_ovf` pulse while running gives, one cycle later, a one-cycle `chip_rst`, `to_flag`=1 and `pdf`=0. The block stays running. If it coincides with `halt_req`, the overflow wins and no halt happens.
- R6: A `wdt_ovf` pulse while halted gives, one cycle later, a one-cycle `warm_rst`, `to_flag`=1, `pdf` unchanged at 1, no `chip_rst`, and the return to running.
- R7: While halted, any bit set in both `irq_pend` and `irq_en` gives, one cycle later, a one-cycle `resume` and the return to running. `pdf` and `to_flag` keep their values.
- R8: A pending interrupt whose enable bit is 0 does not wake the block: no strobe, and `sys_clk_en` stays 0.
- R9: While halted, a high-to-low change on any `porta` bit, after a two-stage synchroniser, gives one `resume` strobe. A low-to-high change gives none. Pins idle high.
- R10: `halt_req` while already halted has no effect: no `wdt_clr`, and the flags are unchanged.
- R11: `rst_n` low clears `pdf` and `to_flag` and returns the block to running from the halted state.
- R12: At most one of `wdt_clr`, `chip_rst`, `warm_rst` and `resume` is high in any cycle.
- R13: When a watchdog overflow and a wake interrupt arrive together while halted, the block gives `warm_rst` and no `resume`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, free-running |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| halt_req | input | 1 | One-cycle strobe from a decoded halt instruction |
| wdt_ovf | input | 1 | One-cycle watchdog overflow strobe |
| wdt_osc_sel | input | 1 | 1 when the watchdog counts from its own oscillator |
| irq_pend | input | IRQ_W | Pending interrupt requests |
| irq_en | input | IRQ_W | Interrupt enable mask |
| porta | input | PA_W | Asynchronous port-A pin levels |
| sys_clk_en | output | 1 | Core clock enable |
| wdt_tick_en | output | 1 | Watchdog tick enable |
| wdt_clr | output | 1 | Watchdog and prescaler clear strobe |
| chip_rst | output | 1 | Full chip reset strobe |
| warm_rst | output | 1 | Program counter and stack pointer reset strobe |
| resume | output | 1 | Resume-without-reset strobe |
| pdf | output | 1 | Power-down flag |
| to_flag | output | 1 | Timeout flag |

## Verification
The hardest cases to reach from the ports are those that need two wake causes in the same cycle, and the port-edge path, whose strobe only appears several cycles after the pin changes because of the synchroniser. The bench enters the halted state first and then drives the watchdog overflow and an enabled interrupt on the same falling clock edge, so the priority decides. Port edges are checked through a strobe counter over a fixed window rather than at a guessed cycle. A rising edge and a masked interrupt are each given the same window, and the bench confirms that nothing woke the block during it.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
   typedef enum logic [0:0] {
      ST_RUN  = 1'b0,
      ST_HALT = 1'b1
   } hwc_state_e;

   typedef enum logic [1:0] {
      WK_NONE = 2'd0,
      WK_WDT  = 2'd1,
      WK_IRQ  = 2'd2,
      WK_PORT = 2'd3
   } hwc_wake_e;
endpackage

// File: rtl/hwc_port_watch.sv
module hwc_port_watch #(
   parameter int PA_W        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PA_W-1:0] pins_i,
   input  logic            armed_i,
   output logic            fall_o
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [PA_W-1:0] stg_q [SYNC_STAGES];
   logic [PA_W-1:0] prev_q;
   logic [PA_W-1:0] fall_vec;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '1;
            else        stg_q[g] <= pins_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '1;
            else        stg_q[g] <= stg_q[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= stg_q[LAST];
   end

   always_comb begin
      fall_vec = prev_q & ~stg_q[LAST];
      fall_o   = armed_i & (|fall_vec);
   end

   // R9: a reported fall means some synchronised pin was high last cycle and is low now
   p_fall_real_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> (stg_q[LAST] != $past(stg_q[LAST])));
endmodule

// File: rtl/hwc_wake_sel.sv
module hwc_wake_sel
   import hwc_pkg::*;
#(
   parameter int IRQ_W = 4
) (
   input  logic             halted_i,
   input  logic             wdt_ovf_i,
   input  logic [IRQ_W-1:0] irq_pend_i,
   input  logic [IRQ_W-1:0] irq_en_i,
   input  logic             port_fall_i,
   output hwc_wake_e        cause_o
);
   logic irq_hit;

   always_comb begin
      irq_hit = |(irq_pend_i & irq_en_i);
      cause_o = WK_NONE;
      if (halted_i) begin
         if (wdt_ovf_i)        cause_o = WK_WDT;
         else if (irq_hit)     cause_o = WK_IRQ;
         else if (port_fall_i) cause_o = WK_PORT;
      end
   end
endmodule

// File: rtl/hwc_status_flags.sv
module hwc_status_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_halt_i,
   input  logic ev_full_i,
   input  logic ev_warm_i,
   output logic pdf_o,
   output logic to_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pdf_o <= 1'b0;
         to_o  <= 1'b0;
      end else if (ev_full_i) begin
         pdf_o <= 1'b0;
         to_o  <= 1'b1;
      end else if (ev_warm_i) begin
         to_o  <= 1'b1;
      end else if (ev_halt_i) begin
         pdf_o <= 1'b1;
         to_o  <= 1'b0;
      end
   end

   // R2: entering halt leaves the power-down flag set and the timeout flag clear
   p_halt_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_halt_i && !ev_full_i && !ev_warm_i) |=> (pdf_o && !to_o));
   // R6: a warm restart never touches the power-down flag
   p_warm_keeps_pdf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_warm_i |=> (to_o && $stable(pdf_o)));
endmodule

// File: rtl/hwc_halt_ctrl.sv
module hwc_halt_ctrl
   import hwc_pkg::*;
#(
   parameter int PA_W        = 8,
   parameter int IRQ_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt_req,
   input  logic             wdt_ovf,
   input  logic             wdt_osc_sel,
   input  logic [IRQ_W-1:0] irq_pend,
   input  logic [IRQ_W-1:0] irq_en,
   input  logic [PA_W-1:0]  porta,
   output logic             sys_clk_en,
   output logic             wdt_tick_en,
   output logic             wdt_clr,
   output logic             chip_rst,
   output logic             warm_rst,
   output logic             resume,
   output logic             pdf,
   output logic             to_flag
);
   if (PA_W < 1) begin : g_bad_pa
      $error("hwc_halt_ctrl: PA_W must be at least 1");
   end
   if (IRQ_W < 1) begin : g_bad_irq
      $error("hwc_halt_ctrl: IRQ_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hwc_halt_ctrl: SYNC_STAGES must be at least 2");
   end

   hwc_state_e state_q;
   hwc_wake_e  cause;
   logic       halted;
   logic       port_fall;
   logic       ev_halt, ev_full, ev_warm;

   assign halted = (state_q == ST_HALT);

   hwc_port_watch #(.PA_W(PA_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins_i (porta),
      .armed_i(halted),
      .fall_o (port_fall)
   );

   hwc_wake_sel #(.IRQ_W(IRQ_W)) u_wake (
      .halted_i   (halted),
      .wdt_ovf_i  (wdt_ovf),
      .irq_pend_i (irq_pend),
      .irq_en_i   (irq_en),
      .port_fall_i(port_fall),
      .cause_o    (cause)
   );

   always_comb begin
      ev_full = !halted && wdt_ovf;
      ev_halt = !halted && !wdt_ovf && halt_req;
      ev_warm = (cause == WK_WDT);
   end

   hwc_status_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_halt_i(ev_halt),
      .ev_full_i(ev_full),
      .ev_warm_i(ev_warm),
      .pdf_o    (pdf),
      .to_o     (to_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_RUN;
         wdt_clr  <= 1'b0;
         chip_rst <= 1'b0;
         warm_rst <= 1'b0;
         resume   <= 1'b0;
      end else begin
         wdt_clr  <= 1'b0;
         chip_rst <= 1'b0;
         warm_rst <= 1'b0;
         resume   <= 1'b0;
         unique case (state_q)
            ST_RUN: begin
               if (ev_full) begin
                  chip_rst <= 1'b1;
               end else if (ev_halt) begin
                  wdt_clr <= 1'b1;
                  state_q <= ST_HALT;
               end
            end
            ST_HALT: begin
               unique case (cause)
                  WK_WDT: begin
                     warm_rst <= 1'b1;
                     state_q  <= ST_RUN;
                  end
                  WK_IRQ, WK_PORT: begin
                     resume  <= 1'b1;
                     state_q <= ST_RUN;
                  end
                  default: ;
               endcase
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   always_comb begin
      sys_clk_en  = !halted;
      wdt_tick_en = !halted || wdt_osc_sel;
   end

   // R12: restart strobes are mutually exclusive
   p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wdt_clr, chip_rst, warm_rst, resume}));
   // R3: the core clock only stops right after a halt request
   p_gate_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_clk_en) |-> ($past(halt_req) && wdt_clr));
   // R5: overflow while running resets the whole chip and records timeout
   p_wdt_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_clk_en && wdt_ovf) |=> (chip_rst && to_flag && !pdf && sys_clk_en));
   // R6: overflow while halted is only a warm restart
   p_wdt_warm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_clk_en && wdt_ovf) |=> (warm_rst && !chip_rst && sys_clk_en));
   // R7: a plain resume leaves both flags alone
   p_resume_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resume |-> ($stable(pdf) && $stable(to_flag)));
   // R13: overflow outranks an interrupt wake
   p_prio_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_clk_en && wdt_ovf && (|(irq_pend & irq_en))) |=> !resume);
   // R10: a repeated halt request while halted asks for no watchdog clear
   p_halt_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_clk_en && halt_req) |=> !wdt_clr);
endmodule

// File: tb/hwc_halt_ctrl_tb.sv
module hwc_halt_ctrl_tb;
   localparam int PA_W  = 8;
   localparam int IRQ_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             halt_req = 1'b0, wdt_ovf = 1'b0, wdt_osc_sel = 1'b0;
   logic [IRQ_W-1:0] irq_pend = '0, irq_en = '0;
   logic [PA_W-1:0]  porta = '1;
   logic sys_clk_en, wdt_tick_en, wdt_clr, chip_rst, warm_rst, resume, pdf, to_flag;

   int checks = 0, failures = 0, n_resume = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hwc_halt_ctrl #(.PA_W(PA_W), .IRQ_W(IRQ_W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wdt_ovf(wdt_ovf),
      .wdt_osc_sel(wdt_osc_sel), .irq_pend(irq_pend), .irq_en(irq_en),
      .porta(porta), .sys_clk_en(sys_clk_en), .wdt_tick_en(wdt_tick_en),
      .wdt_clr(wdt_clr), .chip_rst(chip_rst), .warm_rst(warm_rst),
      .resume(resume), .pdf(pdf), .to_flag(to_flag));

   always @(negedge clk) if (resume) n_resume++;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      #1;
      chk("R11 pdf cleared in reset", int'(pdf), 0);
      chk("R11 to cleared in reset", int'(to_flag), 0);
      chk("R11 run in reset", int'(sys_clk_en), 1);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic enter_halt();
      @(negedge clk) halt_req = 1'b1;
      @(negedge clk) halt_req = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 pdf", int'(pdf), 0);
      chk("R1 to", int'(to_flag), 0);
      chk("R1 sys_clk_en", int'(sys_clk_en), 1);
      chk("R1 strobes", int'({wdt_clr, chip_rst, warm_rst, resume}), 0);
   endtask

   task automatic t_halt_entry();
      do_reset();
      @(negedge clk) wdt_ovf = 1'b1;
      @(negedge clk) wdt_ovf = 1'b0;
      enter_halt();
      chk("R2 wdt_clr", int'(wdt_clr), 1);
      chk("R2 pdf", int'(pdf), 1);
      chk("R2 to cleared", int'(to_flag), 0);
      chk("R3 clock gated", int'(sys_clk_en), 0);
      @(negedge clk);
      chk("R2 wdt_clr one cycle", int'(wdt_clr), 0);
      chk("R3 still gated", int'(sys_clk_en), 0);
   endtask

   task automatic t_tick_sel();
      do_reset();
      chk("R4 tick in run", int'(wdt_tick_en), 1);
      enter_halt();
      wdt_osc_sel = 1'b0; #1;
      chk("R4 tick off halted", int'(wdt_tick_en), 0);
      wdt_osc_sel = 1'b1; #1;
      chk("R4 tick on halted osc", int'(wdt_tick_en), 1);
      wdt_osc_sel = 1'b0;
   endtask

   task automatic t_wdt_run();
      do_reset();
      @(negedge clk) begin wdt_ovf = 1'b1; halt_req = 1'b1; end
      @(negedge clk) begin wdt_ovf = 1'b0; halt_req = 1'b0; end
      chk("R5 chip_rst", int'(chip_rst), 1);
      chk("R5 to set", int'(to_flag), 1);
      chk("R5 pdf clear", int'(pdf), 0);
      chk("R5 stays running", int'(sys_clk_en), 1);
      chk("R5 overflow beats halt", int'(wdt_clr), 0);
   endtask

   task automatic t_wdt_halt();
      do_reset();
      enter_halt();
      @(negedge clk) wdt_ovf = 1'b1;
      @(negedge clk) wdt_ovf = 1'b0;
      chk("R6 warm_rst", int'(warm_rst), 1);
      chk("R6 no chip_rst", int'(chip_rst), 0);
      chk("R6 to set", int'(to_flag), 1);
      chk("R6 pdf kept", int'(pdf), 1);
      chk("R3 clock back", int'(sys_clk_en), 1);
   endtask

   task automatic t_irq_wake();
      do_reset();
      enter_halt();
      @(negedge clk) begin irq_pend = 4'b0100; irq_en = 4'b0110; end
      @(negedge clk) begin irq_pend = '0; irq_en = '0; end
      chk("R7 resume", int'(resume), 1);
      chk("R7 pdf kept", int'(pdf), 1);
      chk("R7 to kept", int'(to_flag), 0);
      chk("R7 running", int'(sys_clk_en), 1);
   endtask

   task automatic t_masked_irq();
      do_reset();
      enter_halt();
      n_resume = 0;
      @(negedge clk) begin irq_pend = 4'b1000; irq_en = 4'b0111; end
      repeat (5) @(negedge clk);
      chk("R8 no resume", n_resume, 0);
      chk("R8 still halted", int'(sys_clk_en), 0);
      irq_pend = '0; irq_en = '0;
   endtask

   task automatic t_port();
      do_reset();
      @(negedge clk) porta = 8'hEF;
      repeat (4) @(negedge clk);
      enter_halt();
      n_resume = 0;
      @(negedge clk) porta = 8'hFF;
      repeat (6) @(negedge clk);
      chk("R9 rise ignored", n_resume, 0);
      chk("R9 halted after rise", int'(sys_clk_en), 0);
      @(negedge clk) porta = 8'hFD;
      repeat (6) @(negedge clk);
      chk("R9 fall wakes once", n_resume, 1);
      chk("R9 running after fall", int'(sys_clk_en), 1);
      porta = 8'hFF;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_halt_ignored();
      do_reset();
      enter_halt();
      @(negedge clk) halt_req = 1'b1;
      @(negedge clk) halt_req = 1'b0;
      chk("R10 no wdt_clr", int'(wdt_clr), 0);
      chk("R10 pdf kept", int'(pdf), 1);
      chk("R10 still halted", int'(sys_clk_en), 0);
   endtask

   task automatic t_priority();
      do_reset();
      enter_halt();
      @(negedge clk) begin wdt_ovf = 1'b1; irq_pend = 4'b0001; irq_en = 4'b0001; end
      @(negedge clk) begin wdt_ovf = 1'b0; irq_pend = '0; irq_en = '0; end
      chk("R13 warm_rst wins", int'(warm_rst), 1);
      chk("R13 no resume", int'(resume), 0);
   endtask

   task automatic t_ext_reset();
      do_reset();
      enter_halt();
      @(negedge clk) wdt_ovf = 1'b1;
      @(negedge clk) wdt_ovf = 1'b0;
      enter_halt();
      chk("R11 halted before reset", int'(sys_clk_en), 0);
      do_reset();
      chk("R11 flags cleared pdf", int'(pdf), 0);
      chk("R11 flags cleared to", int'(to_flag), 0);
      chk("R11 back to run", int'(sys_clk_en), 1);
   endtask

   task automatic t_exclusive();
      chk("R12 one strobe", int'($countones({wdt_clr, chip_rst, warm_rst, resume}) <= 1), 1);
   endtask

   initial begin
      t_reset_state();
      t_halt_entry();
      t_tick_sel();
      t_wdt_run();
      t_wdt_halt();
      t_exclusive();
      t_irq_wake();
      t_masked_irq();
      t_port();
      t_halt_ignored();
      t_priority();
      t_ext_reset();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule